// File: doc/BRIEF.md
# PI Compensator with Conditional Anti-Windup

This block is the proportional-plus-integral stage of a motor current or speed loop. Once per control period the loop logic pulses `start` with a fresh signed error sample. The block multiplies the error by a proportional gain and by an integral gain, adds the integral contribution to a wide running sum and forms the new control output. It clamps that output to a programmable window and pulses `done` when the result is ready.

The integral term is held in a 32-bit accumulator with eight fraction bits, so that very small errors still build up over many periods. The output is taken as the arithmetic right shift by eight of the proportional product plus the accumulator. Anti-windup is conditional: a sample is skipped by the integrator only when adding it would drive the output further past the limit it already exceeds. An error that pulls the output back toward the window is always integrated, so the loop leaves saturation on the first sample that asks for it.

The update is a three-stage pipeline. Starts may arrive on consecutive cycles, and each gets its own `done` pulse in the same order. The output holds its last value between updates.

Top module: `pi_comp`

## Requirements
- R1: A synchronous active-high reset clears the integral accumulator to zero and drives `y` to 0 and `done` to 0. The first update after reset sees an accumulator of zero.
- R2: `done` is high for one cycle, on the third rising edge counting the edge that samples `start` high. `done` never rises without such a `start`.
- R3: `err`, `lim_hi`, `lim_lo` and `y` are two's complement. `kp` and `ki` are unsigned with eight fraction bits, so 0x0100 is a gain of 1.0. Within the limits, `y` equals floor((err*kp + A) / 256), where A is the accumulator after this sample's integration step.
- R4: Each update whose step is not held adds err*ki to the accumulator. The accumulator has 32 bits, eight of them fraction bits, so an error of 1 with a `ki` of 0x0001 raises `y` by one after 256 updates.
- R5: When the unclamped value exceeds `lim_hi`, `y` equals `lim_hi`. When it is below `lim_lo`, `y` equals `lim_lo`. The limits are sampled with `start`, and `lim_lo <= lim_hi` is assumed.
- R6: The integration step of a sample is skipped only in two cases. One is when err*ki is positive and the trial output with it exceeds `lim_hi`. The other is when err*ki is negative and the trial output is below `lim_lo`. Otherwise the step is always taken.
- R7: Between `done` pulses, `y` holds its value whatever the other inputs do.
- R8: Starts on consecutive cycles are processed in order. Each sample's integration step sees the accumulator left by the sample before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request for one compensator update |
| err | input | DATA_W | Signed error sample |
| kp | input | GAIN_W | Proportional gain, unsigned, FRAC_W fraction bits |
| ki | input | GAIN_W | Integral gain, unsigned, FRAC_W fraction bits |
| lim_hi | input | DATA_W | Signed upper output limit |
| lim_lo | input | DATA_W | Signed lower output limit |
| y | output | DATA_W | Signed control output, held between updates |
| done | output | 1 | One-cycle pulse when `y` carries a new result |

## Verification
The bench builds the block with its defaults: 16-bit data and gains, a 32-bit accumulator and eight fraction bits. With these values, gains near full scale against large errors drive the output hard into both limits. A unit error with the smallest integral gain needs exactly 256 updates to move the output by one step, which probes the fractional accumulation directly. Narrow limit windows put the held-integration path and its release within a few samples, and three back-to-back starts exercise the ordering of accumulator updates in the pipeline.

// File: rtl/pi_pkg.sv
package pi_pkg;

    localparam int unsigned PI_DATA_W = 16;
    localparam int unsigned PI_GAIN_W = 16;
    localparam int unsigned PI_ACC_W  = 32;
    localparam int unsigned PI_FRAC_W = 8;

    // Which side of the output window a result landed on
    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_HIGH = 2'd1,
        CLAMP_LOW  = 2'd2
    } clamp_e;

    // Decision taken on the integrator for one sample
    typedef enum logic [1:0] {
        INTEG_IDLE = 2'd0,
        INTEG_STEP = 2'd1,
        INTEG_HOLD = 2'd2
    } integ_e;

    function automatic int unsigned max_w(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pi_product_stage.sv
module pi_product_stage
    import pi_pkg::*;
#(
    parameter int unsigned DATA_W = PI_DATA_W,
    parameter int unsigned GAIN_W = PI_GAIN_W,
    parameter int unsigned PROD_W = DATA_W + GAIN_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic signed [DATA_W-1:0] err_i,
    input  logic        [GAIN_W-1:0] kp_i,
    input  logic        [GAIN_W-1:0] ki_i,
    input  logic signed [DATA_W-1:0] hi_i,
    input  logic signed [DATA_W-1:0] lo_i,
    output logic                     v_o,
    output logic signed [PROD_W-1:0] p_o,
    output logic signed [PROD_W-1:0] inc_o,
    output logic signed [DATA_W-1:0] hi_o,
    output logic signed [DATA_W-1:0] lo_o
);

    logic signed [PROD_W-1:0] err_x;
    logic signed [PROD_W-1:0] kp_x;
    logic signed [PROD_W-1:0] ki_x;
    logic signed [PROD_W-1:0] p_c;
    logic signed [PROD_W-1:0] inc_c;

    // Gains are unsigned: widen with a zero so the signed product stays exact
    always_comb begin
        err_x = PROD_W'(err_i);
        kp_x  = $signed(PROD_W'({1'b0, kp_i}));
        ki_x  = $signed(PROD_W'({1'b0, ki_i}));
        p_c   = err_x * kp_x;
        inc_c = err_x * ki_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o   <= 1'b0;
            p_o   <= '0;
            inc_o <= '0;
            hi_o  <= '0;
            lo_o  <= '0;
        end else begin
            v_o <= start_i;
            if (start_i) begin
                p_o   <= p_c;
                inc_o <= inc_c;
                hi_o  <= hi_i;
                lo_o  <= lo_i;
            end
        end
    end

endmodule

// File: rtl/pi_integrator.sv
module pi_integrator
    import pi_pkg::*;
#(
    parameter int unsigned DATA_W = PI_DATA_W,
    parameter int unsigned PROD_W = 2 * PI_DATA_W + 1,
    parameter int unsigned ACC_W  = PI_ACC_W,
    parameter int unsigned FRAC_W = PI_FRAC_W,
    parameter int unsigned SUM_W  = max_w(PROD_W, ACC_W) + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     v_i,
    input  logic signed [PROD_W-1:0] p_i,
    input  logic signed [PROD_W-1:0] inc_i,
    input  logic signed [DATA_W-1:0] hi_i,
    input  logic signed [DATA_W-1:0] lo_i,
    output logic                     v_o,
    output logic signed [PROD_W-1:0] p_o,
    output logic signed [ACC_W-1:0]  acc_o,
    output logic signed [DATA_W-1:0] hi_o,
    output logic signed [DATA_W-1:0] lo_o
);

    localparam logic signed [SUM_W-1:0] ACC_MAX =
        $signed({{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}});
    localparam logic signed [SUM_W-1:0] ACC_MIN =
        $signed({{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}});

    logic signed [ACC_W-1:0] acc_q;
    logic signed [SUM_W-1:0] raw_sum;
    logic signed [ACC_W-1:0] cand;
    logic signed [SUM_W-1:0] trial_sum;
    logic signed [SUM_W-1:0] trial_u;
    logic signed [SUM_W-1:0] hi_x;
    logic signed [SUM_W-1:0] lo_x;
    logic                    inc_pos;
    logic                    inc_neg;
    integ_e                  action;

    // Candidate accumulator, saturated to the accumulator range
    always_comb begin
        raw_sum = SUM_W'(acc_q) + SUM_W'(inc_i);
        if (raw_sum > ACC_MAX) begin
            cand = ACC_MAX[ACC_W-1:0];
        end else if (raw_sum < ACC_MIN) begin
            cand = ACC_MIN[ACC_W-1:0];
        end else begin
            cand = raw_sum[ACC_W-1:0];
        end
    end

    // Trial output with this sample integrated; decides hold versus step
    always_comb begin
        trial_sum = SUM_W'(p_i) + SUM_W'(cand);
        trial_u   = trial_sum >>> FRAC_W;
        hi_x      = SUM_W'(hi_i);
        lo_x      = SUM_W'(lo_i);
        inc_neg   = inc_i[PROD_W-1];
        inc_pos   = !inc_i[PROD_W-1] && (inc_i != '0);
        if (!v_i) begin
            action = INTEG_IDLE;
        end else if ((trial_u > hi_x && inc_pos) || (trial_u < lo_x && inc_neg)) begin
            action = INTEG_HOLD;
        end else begin
            action = INTEG_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            v_o   <= 1'b0;
            p_o   <= '0;
            hi_o  <= '0;
            lo_o  <= '0;
        end else begin
            v_o <= v_i;
            if (action == INTEG_STEP) begin
                acc_q <= cand;
            end
            if (v_i) begin
                p_o  <= p_i;
                hi_o <= hi_i;
                lo_o <= lo_i;
            end
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/pi_output_stage.sv
module pi_output_stage
    import pi_pkg::*;
#(
    parameter int unsigned DATA_W = PI_DATA_W,
    parameter int unsigned PROD_W = 2 * PI_DATA_W + 1,
    parameter int unsigned ACC_W  = PI_ACC_W,
    parameter int unsigned FRAC_W = PI_FRAC_W,
    parameter int unsigned SUM_W  = max_w(PROD_W, ACC_W) + 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     v_i,
    input  logic signed [PROD_W-1:0] p_i,
    input  logic signed [ACC_W-1:0]  acc_i,
    input  logic signed [DATA_W-1:0] hi_i,
    input  logic signed [DATA_W-1:0] lo_i,
    output logic signed [DATA_W-1:0] y_o,
    output logic                     done_o
);

    logic signed [SUM_W-1:0]  sum;
    logic signed [SUM_W-1:0]  u;
    logic signed [DATA_W-1:0] y_n;
    clamp_e                   dir;

    always_comb begin
        sum = SUM_W'(p_i) + SUM_W'(acc_i);
        u   = sum >>> FRAC_W;
        if (u > SUM_W'(hi_i)) begin
            dir = CLAMP_HIGH;
        end else if (u < SUM_W'(lo_i)) begin
            dir = CLAMP_LOW;
        end else begin
            dir = CLAMP_NONE;
        end
        unique case (dir)
            CLAMP_HIGH: y_n = hi_i;
            CLAMP_LOW:  y_n = lo_i;
            default:    y_n = u[DATA_W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_o    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= v_i;
            if (v_i) begin
                y_o <= y_n;
            end
        end
    end

endmodule

// File: rtl/pi_comp.sv
module pi_comp
    import pi_pkg::*;
#(
    parameter int unsigned DATA_W = PI_DATA_W,
    parameter int unsigned GAIN_W = PI_GAIN_W,
    parameter int unsigned ACC_W  = PI_ACC_W,
    parameter int unsigned FRAC_W = PI_FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic signed [DATA_W-1:0] err,
    input  logic        [GAIN_W-1:0] kp,
    input  logic        [GAIN_W-1:0] ki,
    input  logic signed [DATA_W-1:0] lim_hi,
    input  logic signed [DATA_W-1:0] lim_lo,
    output logic signed [DATA_W-1:0] y,
    output logic                     done
);

    localparam int unsigned PROD_W = DATA_W + GAIN_W + 1;
    localparam int unsigned SUM_W  = max_w(PROD_W, ACC_W) + 2;

    logic                     s1_v;
    logic signed [PROD_W-1:0] s1_p;
    logic signed [PROD_W-1:0] s1_inc;
    logic signed [DATA_W-1:0] s1_hi;
    logic signed [DATA_W-1:0] s1_lo;

    logic                     s2_v;
    logic signed [PROD_W-1:0] s2_p;
    logic signed [ACC_W-1:0]  s2_acc;
    logic signed [DATA_W-1:0] s2_hi;
    logic signed [DATA_W-1:0] s2_lo;

    pi_product_stage #(
        .DATA_W (DATA_W),
        .GAIN_W (GAIN_W),
        .PROD_W (PROD_W)
    ) u_prod (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .err_i   (err),
        .kp_i    (kp),
        .ki_i    (ki),
        .hi_i    (lim_hi),
        .lo_i    (lim_lo),
        .v_o     (s1_v),
        .p_o     (s1_p),
        .inc_o   (s1_inc),
        .hi_o    (s1_hi),
        .lo_o    (s1_lo)
    );

    pi_integrator #(
        .DATA_W (DATA_W),
        .PROD_W (PROD_W),
        .ACC_W  (ACC_W),
        .FRAC_W (FRAC_W),
        .SUM_W  (SUM_W)
    ) u_integ (
        .clk   (clk),
        .rst   (rst),
        .v_i   (s1_v),
        .p_i   (s1_p),
        .inc_i (s1_inc),
        .hi_i  (s1_hi),
        .lo_i  (s1_lo),
        .v_o   (s2_v),
        .p_o   (s2_p),
        .acc_o (s2_acc),
        .hi_o  (s2_hi),
        .lo_o  (s2_lo)
    );

    pi_output_stage #(
        .DATA_W (DATA_W),
        .PROD_W (PROD_W),
        .ACC_W  (ACC_W),
        .FRAC_W (FRAC_W),
        .SUM_W  (SUM_W)
    ) u_out (
        .clk    (clk),
        .rst    (rst),
        .v_i    (s2_v),
        .p_i    (s2_p),
        .acc_i  (s2_acc),
        .hi_i   (s2_hi),
        .lo_i   (s2_lo),
        .y_o    (y),
        .done_o (done)
    );

endmodule

// File: rtl/pi_comp_checker.sv
module pi_comp_checker #(
    parameter int unsigned DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     start,
    input logic                     done,
    input logic signed [DATA_W-1:0] y,
    input logic signed [DATA_W-1:0] lim_hi,
    input logic signed [DATA_W-1:0] lim_lo
);

    // R1: reset leaves the output idle and zero
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!done && y == '0));

    // R2: a start always yields done three edges later
    a_r2_done_follows_start: assert property (@(posedge clk) disable iff (rst)
        start |-> ##3 done);

    // R2: no done without its start
    a_r2_done_has_cause: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start, 3));

    // R5: a fresh result lies inside the window sampled with its start
    a_r5_within_limits: assert property (@(posedge clk) disable iff (rst)
        (done && $past(lim_lo, 3) <= $past(lim_hi, 3)) |->
            (y <= $past(lim_hi, 3) && y >= $past(lim_lo, 3)));

    // R7: output only moves together with done
    a_r7_output_holds: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(y));

endmodule

bind pi_comp pi_comp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .done   (done),
    .y      (y),
    .lim_hi (lim_hi),
    .lim_lo (lim_lo)
);

// File: tb/sim_pi_comp.sv
module sim_pi_comp;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic signed [15:0] err = '0;
    logic        [15:0] kp = '0;
    logic        [15:0] ki = '0;
    logic signed [15:0] lim_hi = 16'sh7FFF;
    logic signed [15:0] lim_lo = -16'sh7FFF;
    logic signed [15:0] y;
    logic               done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;
    longint m_acc = 0;

    always #5 clk = ~clk;

    pi_comp u0 (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .err    (err),
        .kp     (kp),
        .ki     (ki),
        .lim_hi (lim_hi),
        .lim_lo (lim_lo),
        .y      (y),
        .done   (done)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint sat_acc(input longint v);
        if (v > 64'sd2147483647) return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    // Reference update built from R3..R6
    function automatic logic signed [15:0] model_step(
        input logic signed [15:0] e, input logic [15:0] kpv, input logic [15:0] kiv,
        input logic signed [15:0] lo, input logic signed [15:0] hi);
        longint p, inc, cand, uc, u;
        p    = longint'(e) * longint'(kpv);
        inc  = longint'(e) * longint'(kiv);
        cand = sat_acc(m_acc + inc);
        uc   = (p + cand) >>> 8;
        if (!((uc > hi && inc > 0) || (uc < lo && inc < 0))) m_acc = cand;
        u = (p + m_acc) >>> 8;
        if (u > hi) return hi;
        if (u < lo) return lo;
        return u[15:0];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        m_acc = 0;
    endtask

    task automatic single(input logic signed [15:0] e, input logic [15:0] kpv,
                          input logic [15:0] kiv, input logic signed [15:0] lo,
                          input logic signed [15:0] hi, input string tag,
                          output logic signed [15:0] got);
        logic signed [15:0] exp;
        exp = model_step(e, kpv, kiv, lo, hi);
        @(negedge clk);
        err = e; kp = kpv; ki = kiv; lim_lo = lo; lim_hi = hi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R2 early done", longint'(done), 0);
        @(negedge clk);
        check(done == 1'b1, "R2 done latency", longint'(done), 1);
        check(y == exp, tag, longint'(y), longint'(exp));
        got = y;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic signed [15:0] r;
        logic signed [15:0] held;
        void'($urandom(32'd4711));

        // R1: reset state
        repeat (3) @(negedge clk);
        check(y == 16'sd0, "R1 reset y", longint'(y), 0);
        check(done == 1'b0, "R1 reset done", longint'(done), 0);
        rst = 1'b0;

        // R1: accumulator starts from zero
        single(16'sd100, 16'h0000, 16'h0100, -16'sd32767, 16'sd32767, "R1 first update", r);
        check(r == 16'sd100, "R1 acc zero", longint'(r), 100);

        // R3: proportional part with floor rounding
        single(-16'sd7, 16'h0180, 16'h0000, -16'sd32767, 16'sd32767, "R3 prop", r);
        check(r == 16'sd89, "R3 floor value", longint'(r), 89);
        single(16'sd1234, 16'h0240, 16'h0000, -16'sd32767, 16'sd32767, "R3 prop2", r);

        // R7: output holds while idle inputs change
        held = y;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            err = 16'(i * 999);
            lim_hi = 16'sd5;
            check(done == 1'b0, "R2 idle done", longint'(done), 0);
            check(y == held, "R7 hold", longint'(y), longint'(held));
        end

        // R4: tiny error accumulates in the fraction bits
        do_reset();
        for (int i = 1; i <= 256; i++) begin
            single(16'sd1, 16'h0000, 16'h0001, -16'sd32767, 16'sd32767, "R4 fraction", r);
            if (i == 255) check(r == 16'sd0, "R4 before carry", longint'(r), 0);
            if (i == 256) check(r == 16'sd1, "R4 carry", longint'(r), 1);
        end

        // R5: clamp at both limits
        do_reset();
        single(16'sd30000, 16'h7FFF, 16'h0000, -16'sd2000, 16'sd1500, "R5 high", r);
        check(r == 16'sd1500, "R5 high value", longint'(r), 1500);
        single(-16'sd30000, 16'h7FFF, 16'h0000, -16'sd2000, 16'sd1500, "R5 low", r);
        check(r == -16'sd2000, "R5 low value", longint'(r), -2000);

        // R6: integration held at the limit, released on reversal
        do_reset();
        for (int i = 0; i < 6; i++)
            single(16'sd300, 16'h0000, 16'h0100, -16'sd1000, 16'sd1000, "R6 push", r);
        check(r == 16'sd900, "R6 held", longint'(r), 900);
        single(-16'sd100, 16'h0000, 16'h0100, -16'sd1000, 16'sd1000, "R6 release", r);
        check(r == 16'sd800, "R6 release value", longint'(r), 800);
        for (int i = 0; i < 6; i++)
            single(-16'sd400, 16'h0100, 16'h0100, -16'sd1000, 16'sd1000, "R6 push low", r);

        // R8: three back-to-back starts
        begin
            logic signed [15:0] e0, e1, e2;
            e0 = model_step(16'sd50, 16'h0100, 16'h0080, -16'sd3000, 16'sd3000);
            e1 = model_step(-16'sd20, 16'h0200, 16'h0100, -16'sd3000, 16'sd3000);
            e2 = model_step(16'sd700, 16'h0010, 16'h0300, -16'sd3000, 16'sd3000);
            @(negedge clk);
            err = 16'sd50; kp = 16'h0100; ki = 16'h0080; lim_lo = -16'sd3000; lim_hi = 16'sd3000;
            start = 1'b1;
            @(negedge clk);
            err = -16'sd20; kp = 16'h0200; ki = 16'h0100;
            @(negedge clk);
            err = 16'sd700; kp = 16'h0010; ki = 16'h0300;
            @(negedge clk);
            start = 1'b0;
            check(done == 1'b1 && y == e0, "R8 first", longint'(y), longint'(e0));
            @(negedge clk);
            check(done == 1'b1 && y == e1, "R8 second", longint'(y), longint'(e1));
            @(negedge clk);
            check(done == 1'b1 && y == e2, "R8 third", longint'(y), longint'(e2));
            @(negedge clk);
            check(done == 1'b0, "R2 burst end", longint'(done), 0);
        end

        // R3 R5 R6: constrained random updates
        do_reset();
        for (int i = 0; i < 400; i++) begin
            logic signed [15:0] a, b, lo, hi, e;
            logic [15:0] g1, g2;
            if (i % 100 == 99) do_reset();
            a  = 16'($urandom);
            b  = 16'($urandom);
            lo = (a < b) ? a : b;
            hi = (a < b) ? b : a;
            e  = ($urandom % 4 == 0) ? 16'($urandom) : 16'(int'($urandom % 601) - 300);
            g1 = ($urandom % 2 == 0) ? 16'($urandom % 16'h0400) : 16'($urandom);
            g2 = 16'($urandom % 16'h0200);
            single(e, g1, g2, lo, hi, "R3 random", r);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule